// File: doc/BRIEF.md
# Dual-Bank Interrupt Steering Controller

This block gathers up to 40 level-sensitive interrupt sources and turns them into three request lines for a processor: a fast request, a normal request and an idle wake-up request. Each source's pin level is sampled into a pending bit every clock. A per-source enable bit gates the source, and a per-source steering bit sends an enabled, pending source to the fast line (steering 1) or to the normal line (steering 0). The wake-up line can optionally ignore the enable mask, so that sources the software has masked can still bring the processor out of idle.

Sources are held in two 32-bit banks: sources 0 to 31 in bank 0 and sources 32 to 39 in the low bits of bank 1. A simple word-wide register port reads the pending state, three filtered pending views, the enable and steering words, an idle-control word and one priority word per source. Software writes the enable, steering, idle-control and priority words through the same port. The highest-priority word is computed outside the block and is read back through an input port.

The read side of the port is handled by a two-state access machine. `ACC_IDLE` waits for a read strobe. A read strobe moves it to `ACC_RDATA`, which presents the captured data with a valid flag for one cycle. A further strobe in `ACC_RDATA` keeps it there with new data; otherwise it returns to `ACC_IDLE`.

Top module: `irq_steer_ctrl`

## Requirements
- R1: Source i maps to bank i/32, bit i%32. Bank 0's words sit at base 0x00 and bank 1's words at base 0x9C, with the same layout relative to each base.
- R2: A source's pending bit takes the pin level sampled on each rising clock edge. It is set while the pin is high and clear while it is low, with no latching.
- R3: An enabled, pending source whose steering bit is 1 drives fiq_req; with steering bit 0 it drives irq_req. Both request outputs are registered and reflect the pending, enable and steering state one edge later.
- R4: A source whose enable bit is 0 raises neither fiq_req nor irq_req, whatever its pin level.
- R5: Relative to a bank base, offset +0x00 reads pending & enable & ~steering, +0x0C reads pending & enable & steering, +0x10 reads raw pending, +0x04 reads and writes the enable word, and +0x08 reads and writes the steering word.
- R6: The control word sits at 0x14. Writing bit 0 = 0 makes wake_req follow any pending source, enabled or not. Writing bit 0 = 1 restricts wake_req to enabled pending sources. A read returns bit 0 = 1 in the restricted mode, and the other bits read 0. wake_req is registered like the request outputs.
- R7: Priority word i sits at 0x1C+4*i for i < 32 and at 0xB0+4*(i-32) for i >= 32. Only bit 31 and bits 5:0 of a write are kept, and all other bits read 0.
- R8: Reads of offsets with no register return 0. Writes to them, and writes to the pending and pending-view offsets, change nothing.
- R9: After reset, the pending, enable, steering, control and priority words are 0, and fiq_req, irq_req, wake_req and reg_rvalid are low.
- R10: A read strobe sampled on an edge yields reg_rvalid high with reg_rdata for the whole following cycle. Offset 0x18 returns hp_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_lvl | input | 40 | Source pin levels |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 8 | Byte offset of the word |
| reg_wdata | input | 32 | Write data |
| hp_word | input | 32 | Highest-priority word from the external resolver |
| reg_rdata | output | 32 | Read data, valid while reg_rvalid is high |
| reg_rvalid | output | 1 | Read data valid |
| fiq_req | output | 1 | Fast interrupt request |
| irq_req | output | 1 | Normal interrupt request |
| wake_req | output | 1 | Idle wake-up request |

## Verification
The hardest situation to reach from the ports is a source that is pending but masked. Its steering and enable state must then show in wake_req while both request lines stay low, and that holds only while the control word still permits wake-up from masked sources. The stimulus raises a pin with its enable bit clear and checks that wake_req goes high while fiq_req and irq_req stay low. It then writes the control word to switch to restricted mode and checks that wake_req drops. Finally it enables the same source and toggles its steering bit on a source in the second bank, to show that the bank mapping reaches both request lines.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int BANK_W = 32;
    localparam int ADDR_W = 8;

    // Offsets inside one bank window
    localparam logic [ADDR_W-1:0] OFF_IRQV = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_MASK = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_LVL  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_FIQV = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_RAW  = 8'h10;

    // Global words
    localparam logic [ADDR_W-1:0] ADR_CTRL = 8'h14;
    localparam logic [ADDR_W-1:0] ADR_HP   = 8'h18;

    localparam logic [ADDR_W-1:0] PRIO_LO_BASE = 8'h1C;
    localparam logic [ADDR_W-1:0] PRIO_HI_BASE = 8'hB0;
    localparam logic [ADDR_W-1:0] BANK1_BASE   = 8'h9C;

    localparam logic [31:0] PRIO_KEEP = 32'h8000_003F;

    typedef enum logic [0:0] {
        ACC_IDLE  = 1'b0,
        ACC_RDATA = 1'b1
    } acc_state_e;

    function automatic logic [ADDR_W-1:0] bank_base(input int b);
        return (b == 0) ? 8'h00 : BANK1_BASE;
    endfunction

    function automatic logic [ADDR_W-1:0] prio_addr(input int i);
        if (i < BANK_W)
            return PRIO_LO_BASE + ADDR_W'(4 * i);
        return PRIO_HI_BASE + ADDR_W'(4 * (i - BANK_W));
    endfunction
endpackage

// File: rtl/pic_src_bank.sv
module pic_src_bank
    import pic_pkg::*;
#(
    parameter int BIT_CNT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] pin,
    input  logic              mask_we,
    input  logic              lvl_we,
    input  logic [BANK_W-1:0] wdata,
    input  logic              restrict_wake,
    output logic [BANK_W-1:0] raw,
    output logic [BANK_W-1:0] mask,
    output logic [BANK_W-1:0] lvl,
    output logic [BANK_W-1:0] irq_view,
    output logic [BANK_W-1:0] fiq_view,
    output logic [BANK_W-1:0] wake_view
);
    localparam logic [BANK_W-1:0] LIVE = (BIT_CNT >= BANK_W) ? '1 :
                                         ((BANK_W'(1) << BIT_CNT) - BANK_W'(1));

    logic [BANK_W-1:0] raw_q, mask_q, lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
            lvl_q  <= '0;
        end else begin
            raw_q <= pin & LIVE;
            if (mask_we) mask_q <= wdata & LIVE;
            if (lvl_we)  lvl_q  <= wdata & LIVE;
        end
    end

    always_comb begin
        raw       = raw_q;
        mask      = mask_q;
        lvl       = lvl_q;
        irq_view  = raw_q & mask_q & ~lvl_q;
        fiq_view  = raw_q & mask_q & lvl_q;
        wake_view = raw_q & (mask_q | {BANK_W{~restrict_wake}});
    end
endmodule

// File: rtl/pic_prio_file.sv
module pic_prio_file
    import pic_pkg::*;
#(
    parameter int NSRC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output logic [31:0]       rd_val
);
    logic [31:0] entry_q [NSRC];

    for (genvar i = 0; i < NSRC; i++) begin : g_ent
        localparam logic [ADDR_W-1:0] MY_ADDR = prio_addr(i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                entry_q[i] <= '0;
            else if (wr && wr_addr == MY_ADDR)
                entry_q[i] <= wdata & PRIO_KEEP;
        end
    end

    always_comb begin
        rd_hit = 1'b0;
        rd_val = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (rd_addr == prio_addr(i)) begin
                rd_hit = 1'b1;
                rd_val = entry_q[i];
            end
        end
    end
endmodule

// File: rtl/pic_access_fsm.sv
module pic_access_fsm
    import pic_pkg::*;
#(
    parameter int NBANK = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [NBANK-1:0][BANK_W-1:0] raw,
    input  logic [NBANK-1:0][BANK_W-1:0] mask,
    input  logic [NBANK-1:0][BANK_W-1:0] lvl,
    input  logic [NBANK-1:0][BANK_W-1:0] irqv,
    input  logic [NBANK-1:0][BANK_W-1:0] fiqv,
    input  logic                         restrict_wake,
    input  logic [31:0]                  hp,
    input  logic                         prio_hit,
    input  logic [31:0]                  prio_val,
    output logic [31:0]                  rdata,
    output logic                         rvalid
);
    acc_state_e  state_q, state_d;
    logic [31:0] mux_val, rdata_q;

    always_comb begin
        mux_val = '0;
        if (prio_hit) mux_val = prio_val;
        if (addr == ADR_CTRL) mux_val = {31'd0, restrict_wake};
        if (addr == ADR_HP)   mux_val = hp;
        for (int b = 0; b < NBANK; b++) begin
            if (addr == bank_base(b) + OFF_IRQV) mux_val = irqv[b];
            if (addr == bank_base(b) + OFF_MASK) mux_val = mask[b];
            if (addr == bank_base(b) + OFF_LVL)  mux_val = lvl[b];
            if (addr == bank_base(b) + OFF_FIQV) mux_val = fiqv[b];
            if (addr == bank_base(b) + OFF_RAW)  mux_val = raw[b];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE:  if (rd)  state_d = ACC_RDATA;
            ACC_RDATA: if (!rd) state_d = ACC_IDLE;
            default:            state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd) rdata_q <= mux_val;
        end
    end

    always_comb begin
        rvalid = (state_q == ACC_RDATA);
        rdata  = rvalid ? rdata_q : '0;
    end
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
    import pic_pkg::*;
#(
    parameter int NSRC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_lvl,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [31:0]       hp_word,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    output logic              fiq_req,
    output logic              irq_req,
    output logic              wake_req
);
    localparam int NBANK = (NSRC + BANK_W - 1) / BANK_W;

    logic [NBANK*BANK_W-1:0]      pins_pad;
    logic [NBANK-1:0][BANK_W-1:0] raw_w, mask_w, lvl_w, irqv_w, fiqv_w, wakev_w;
    logic                         restrict_q;
    logic                         prio_hit;
    logic [31:0]                  prio_val;
    logic                         fiq_any, irq_any, wake_any;

    always_comb begin
        pins_pad = '0;
        pins_pad[NSRC-1:0] = src_lvl;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int CNT = (b < NBANK - 1) ? BANK_W : NSRC - BANK_W * b;
        localparam logic [ADDR_W-1:0] BASE = bank_base(b);
        pic_src_bank #(.BIT_CNT(CNT)) u_bank (
            .clk           (clk),
            .rst_n         (rst_n),
            .pin           (pins_pad[b*BANK_W +: BANK_W]),
            .mask_we       (reg_wr && reg_addr == BASE + OFF_MASK),
            .lvl_we        (reg_wr && reg_addr == BASE + OFF_LVL),
            .wdata         (reg_wdata),
            .restrict_wake (restrict_q),
            .raw           (raw_w[b]),
            .mask          (mask_w[b]),
            .lvl           (lvl_w[b]),
            .irq_view      (irqv_w[b]),
            .fiq_view      (fiqv_w[b]),
            .wake_view     (wakev_w[b])
        );
    end

    pic_prio_file #(.NSRC(NSRC)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .wr_addr (reg_addr),
        .wdata   (reg_wdata),
        .rd_addr (reg_addr),
        .rd_hit  (prio_hit),
        .rd_val  (prio_val)
    );

    pic_access_fsm #(.NBANK(NBANK)) u_acc (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd            (reg_rd),
        .addr          (reg_addr),
        .raw           (raw_w),
        .mask          (mask_w),
        .lvl           (lvl_w),
        .irqv          (irqv_w),
        .fiqv          (fiqv_w),
        .restrict_wake (restrict_q),
        .hp            (hp_word),
        .prio_hit      (prio_hit),
        .prio_val      (prio_val),
        .rdata         (reg_rdata),
        .rvalid        (reg_rvalid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            restrict_q <= 1'b0;
        else if (reg_wr && reg_addr == ADR_CTRL)
            restrict_q <= reg_wdata[0];
    end

    assign fiq_any  = |fiqv_w;
    assign irq_any  = |irqv_w;
    assign wake_any = |wakev_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fiq_req  <= 1'b0;
            irq_req  <= 1'b0;
            wake_req <= 1'b0;
        end else begin
            fiq_req  <= fiq_any;
            irq_req  <= irq_any;
            wake_req <= wake_any;
        end
    end
endmodule

// File: rtl/pic_checker.sv
module pic_checker
    import pic_pkg::*;
#(
    parameter int NSRC = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   src_lvl,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              reg_rvalid,
    input logic              fiq_req,
    input logic              irq_req,
    input logic              wake_req,
    input logic              fiq_any,
    input logic              irq_any,
    input logic              wake_any,
    input logic [63:0]       raw_flat
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2
    pend_follows_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> raw_flat[NSRC-1:0] == $past(src_lvl));

    // R3
    fiq_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> fiq_req == $past(fiq_any));

    // R3
    irq_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> irq_req == $past(irq_any));

    // R6
    wake_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> wake_req == $past(wake_any));

    // R10
    rvalid_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> armed && $past(reg_rd));

    // R6
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rvalid && $past(reg_addr) == ADR_CTRL) |-> reg_rdata[31:1] == 31'd0);
endmodule

bind irq_steer_ctrl pic_checker #(.NSRC(NSRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_lvl    (src_lvl),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .fiq_req    (fiq_req),
    .irq_req    (irq_req),
    .wake_req   (wake_req),
    .fiq_any    (fiq_any),
    .irq_any    (irq_any),
    .wake_any   (wake_any),
    .raw_flat   (64'(raw_w))
);

// File: tb/sim_irq_steer_ctrl.sv
module sim_irq_steer_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] src_lvl = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] hp_word = 32'h8021_0005;
    logic [31:0] reg_rdata;
    logic        reg_rvalid, fiq_req, irq_req, wake_req;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_steer_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .hp_word(hp_word),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .fiq_req(fiq_req), .irq_req(irq_req), .wake_req(wake_req)
    );

    // Monitor: pops one expected item per valid read beat
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            total++;
            if (sb_q.size() == 0) begin
                bad++;
                $display("FAIL R10 unexpected read data act=%h exp=none", reg_rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                if (reg_rdata !== it.exp) begin
                    bad++;
                    $display("FAIL %s act=%h exp=%h", it.tag, reg_rdata, it.exp);
                end
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        reg_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(fiq_req, 1'b0, "R9 fiq reset");
        chk(irq_req, 1'b0, "R9 irq reset");
        chk(wake_req, 1'b0, "R9 wake reset");
        chk(reg_rvalid, 1'b0, "R9 rvalid reset");
        rst_n = 1'b1;
        rd(8'h04, 32'h0, "R9 mask reset");
        rd(8'h14, 32'h0, "R9 ctrl reset");
        rd(8'h1C, 32'h0, "R9 prio reset");

        // R2 pending follows the pin
        @(negedge clk); src_lvl[3] = 1'b1;
        rd(8'h10, 32'h8, "R2 raw set");
        @(negedge clk); src_lvl[3] = 1'b0;
        rd(8'h10, 32'h0, "R2 raw clear");

        // R1 bank 1 mapping
        @(negedge clk); src_lvl[35] = 1'b1;
        rd(8'hAC, 32'h8, "R1 bank1 raw");
        rd(8'h10, 32'h0, "R1 bank0 untouched");
        @(negedge clk); src_lvl[35] = 1'b0;

        // R4 masked pending raises no request, R6 wake from masked source
        @(negedge clk); src_lvl[3] = 1'b1;
        settle();
        chk(fiq_req, 1'b0, "R4 masked no fiq");
        chk(irq_req, 1'b0, "R4 masked no irq");
        chk(wake_req, 1'b1, "R6 wake from masked");
        wr(8'h14, 32'h1);
        settle();
        chk(wake_req, 1'b0, "R6 restricted wake");
        rd(8'h14, 32'h1, "R6 ctrl readback");

        // R3 routing
        wr(8'h04, 32'h8);
        wr(8'h08, 32'h8);
        settle();
        chk(fiq_req, 1'b1, "R3 fiq routed");
        chk(irq_req, 1'b0, "R3 irq quiet");
        chk(wake_req, 1'b1, "R6 wake enabled src");
        rd(8'h0C, 32'h8, "R5 fiq view");
        rd(8'h00, 32'h0, "R5 irq view");
        rd(8'h08, 32'h8, "R5 level readback");
        wr(8'h08, 32'h0);
        settle();
        chk(fiq_req, 1'b0, "R3 fiq off");
        chk(irq_req, 1'b1, "R3 irq routed");
        rd(8'h00, 32'h8, "R5 irq view set");
        rd(8'h0C, 32'h0, "R5 fiq view clear");
        @(negedge clk); src_lvl[3] = 1'b0;
        settle();
        chk(irq_req, 1'b0, "R2 irq drops with pin");

        // R1/R3 bank 1 fiq
        wr(8'hA0, 32'h8);
        wr(8'hA4, 32'h8);
        @(negedge clk); src_lvl[35] = 1'b1;
        settle();
        chk(fiq_req, 1'b1, "R1 bank1 fiq");
        rd(8'hA8, 32'h8, "R5 bank1 fiq view");
        @(negedge clk); src_lvl[35] = 1'b0;

        // R7 priority words
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h30, 32'h8000_003F, "R7 prio5 masked");
        wr(8'hCC, 32'h1234_5627);
        rd(8'hCC, 32'h0000_0027, "R7 prio39 masked");

        // R8 undefined offset and read-only writes
        wr(8'hD0, 32'hFFFF_FFFF);
        rd(8'hD0, 32'h0, "R8 undefined read");
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0, "R8 raw write ignored");
        rd(8'h04, 32'h8, "R8 mask untouched");

        // R10 highest-priority passthrough
        rd(8'h18, 32'h8021_0005, "R10 hp word");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            bad++; total++;
            $display("FAIL R10 missing read beats act=%0d exp=0", sb_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule